// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block holds a short queue of one-byte completion reports that a transmit engine produces, one for each finished packet worth reporting. A packet is worth reporting when it ended with an error (jabber, underrun or too many collisions) or when it asked for an interrupt on successful transmission. A clean packet that asked for no interrupt leaves no trace. The host reads the oldest report through a status port. A write strobe to that register discards the oldest report, and the next one moves to the head.

A transmit-complete event stays asserted while the queue holds any report. The queue holds a fixed number of entries, set by a parameter. A report that arrives while the queue is full is dropped. The newest stored entry is then marked with an overflow bit, so the host can see that reports were lost.

Some conditions stop the transmitter: a jabber or underrun report, or a transmit FIFO overrun. The block latches a transmitter-disable level for these. An overrun also sets its own latched flag and pulses an adapter-failure event. A transmit reset clears the latches and empties the queue. The asynchronous block reset clears everything.

Top module: `txc_status_queue`

## Requirements
- R1: A stored report byte carries bit 7 = 1 (complete), bit 6 = interrupt-on-success requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow, and bits 1..0 = 0.
- R2: A finished packet with no error and no interrupt request stores nothing and leaves the status port unchanged.
- R3: Reports leave in arrival order. A stored report is visible on `host_status` in the cycle after its push. A `host_pop` strobe brings the next report to the head one cycle later.
- R4: With the queue empty, `host_status` reads 0x00, and a `host_pop` has no effect.
- R5: A push while the queue is full and no pop happens in the same cycle drops the report and sets bit 2 of the newest stored entry.
- R6: A push and a pop in the same cycle on a full queue both take effect, and no overflow is marked.
- R7: `tx_complete` is high exactly while the queue holds at least one report.
- R8: A finished packet with jabber or underrun sets `tx_disabled` one cycle later, even if its report is dropped. The level holds until a transmit reset or block reset. A maximum-collisions report alone does not disable.
- R9: A `fifo_overrun` event sets `tx_overrun_flag` and `tx_disabled`, and pulses `adapter_fail` high for exactly one cycle, all visible one cycle after the event.
- R10: `tx_reset` empties the queue and clears `tx_disabled` and `tx_overrun_flag` on the next cycle. It takes priority over any push, pop or fatal event in the same cycle.
- R11: An active-low `rst_n` clears the queue and all latches asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pkt_done | input | 1 | Transmit engine finished a packet this cycle |
| pkt_intr_req | input | 1 | Finished packet asked for an interrupt on success |
| pkt_jabber | input | 1 | Finished packet ended in jabber |
| pkt_underrun | input | 1 | Finished packet ended in underrun |
| pkt_max_coll | input | 1 | Finished packet hit maximum collisions |
| fifo_overrun | input | 1 | Transmit FIFO overrun event |
| host_pop | input | 1 | Host write strobe to the status register (pop) |
| tx_reset | input | 1 | Transmit reset command |
| host_status | output | 8 | Oldest report, or 0x00 when empty |
| tx_complete | output | 1 | Queue non-empty event |
| tx_disabled | output | 1 | Transmitter disabled by a fatal condition |
| tx_overrun_flag | output | 1 | Latched transmit FIFO overrun flag |
| adapter_fail | output | 1 | One-cycle adapter-failure event on overrun |

## Verification
Every result of this block is one register stage away from its cause. A push, pop, overrun, fatal report or transmit reset driven in one cycle shows on `host_status`, `tx_complete`, `tx_disabled`, `tx_overrun_flag` and `adapter_fail` right after the next rising edge. The bench drives each stimulus just after a falling edge and holds it across exactly one rising edge. It compares all outputs at the falling edge that follows, before it drives the next stimulus. That sample point also catches a pulse that is wrongly stretched, because the following row expects the pulse low. The asynchronous reset is checked mid-run, a half cycle after it is asserted, with no clock edge needed.

// File: rtl/txc_pkg.sv
package txc_pkg;

  localparam int STAT_W       = 8;
  localparam int BIT_COMPLETE = 7;
  localparam int BIT_INTR     = 6;
  localparam int BIT_JABBER   = 5;
  localparam int BIT_UNDERRUN = 4;
  localparam int BIT_MAXCOLL  = 3;
  localparam int BIT_OVERFLOW = 2;

  typedef struct packed {
    logic intr_req;
    logic jabber;
    logic underrun;
    logic max_coll;
  } txc_report_t;

  // Build the stored byte from one packet outcome.
  function automatic logic [STAT_W-1:0] txc_encode(input txc_report_t r);
    logic [STAT_W-1:0] b;
    b = '0;
    b[BIT_COMPLETE] = 1'b1;
    b[BIT_INTR]     = r.intr_req;
    b[BIT_JABBER]   = r.jabber;
    b[BIT_UNDERRUN] = r.underrun;
    b[BIT_MAXCOLL]  = r.max_coll;
    return b;
  endfunction

  function automatic logic txc_worth_queuing(input txc_report_t r);
    return r.intr_req | r.jabber | r.underrun | r.max_coll;
  endfunction

  function automatic logic txc_is_fatal(input txc_report_t r);
    return r.jabber | r.underrun;
  endfunction

  // Circular pointer step forward and back for any depth.
  function automatic int unsigned ptr_fwd(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ptr_back(input int unsigned p, input int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/txc_ring.sv
module txc_ring #(
  parameter int DEPTH   = 4,
  parameter int WIDTH   = 8,
  parameter int OVF_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  import txc_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [WIDTH-1:0] slot [DEPTH];

  // Named internal events
  logic             rd_take;     // pop that really removes an entry
  logic             wr_take;     // push that really stores an entry
  logic             mark_drop;   // push lost because the ring is full
  logic [PTR_W-1:0] newest_ptr;

  assign empty      = (count == '0);
  assign full       = (count == CNT_W'(DEPTH));
  assign rd_take    = rd_en & ~empty & ~flush;
  assign wr_take    = wr_en & ~flush & (~full | rd_take);
  assign mark_drop  = wr_en & ~flush & full & ~rd_take;
  assign newest_ptr = PTR_W'(ptr_back(int'(wr_ptr), DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (wr_take && wr_ptr == PTR_W'(g)) begin
        slot[g] <= wr_data;
      end else if (mark_drop && newest_ptr == PTR_W'(g)) begin
        slot[g][OVF_BIT] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_take) wr_ptr <= PTR_W'(ptr_fwd(int'(wr_ptr), DEPTH));
      if (rd_take) rd_ptr <= PTR_W'(ptr_fwd(int'(rd_ptr), DEPTH));
      case ({wr_take, rd_take})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = empty ? '0 : slot[rd_ptr];

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R10
  AST_POP_EMPTY_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en && !flush) |=> empty); // R4
  AST_DROP_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en && !flush) |=> full); // R5
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> !empty); // R3

endmodule

// File: rtl/txc_fatal_latch.sv
module txc_fatal_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_reset,
  input  logic fatal_report,
  input  logic overrun_evt,
  output logic tx_disabled,
  output logic overrun_flag,
  output logic fail_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_disabled  <= 1'b0;
      overrun_flag <= 1'b0;
      fail_pulse   <= 1'b0;
    end else if (tx_reset) begin
      tx_disabled  <= 1'b0;
      overrun_flag <= 1'b0;
      fail_pulse   <= 1'b0;
    end else begin
      if (fatal_report || overrun_evt) tx_disabled <= 1'b1;
      if (overrun_evt) overrun_flag <= 1'b1;
      fail_pulse <= overrun_evt;
    end
  end

  AST_DISABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_disabled && !tx_reset) |=> tx_disabled); // R8
  AST_FATAL_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_report && !tx_reset) |=> tx_disabled); // R8
  AST_OVERRUN_EFFECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_evt && !tx_reset) |=> (tx_disabled && overrun_flag && fail_pulse)); // R9
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_pulse && !overrun_evt) |=> !fail_pulse); // R9
  AST_TXRESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (!tx_disabled && !overrun_flag && !fail_pulse)); // R10

endmodule

// File: rtl/txc_status_queue.sv
module txc_status_queue #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_done,
  input  logic       pkt_intr_req,
  input  logic       pkt_jabber,
  input  logic       pkt_underrun,
  input  logic       pkt_max_coll,
  input  logic       fifo_overrun,
  input  logic       host_pop,
  input  logic       tx_reset,
  output logic [7:0] host_status,
  output logic       tx_complete,
  output logic       tx_disabled,
  output logic       tx_overrun_flag,
  output logic       adapter_fail
);
  import txc_pkg::*;

  txc_report_t       rep;
  logic              push_req;
  logic              fatal_req;
  logic              ring_empty;
  logic              ring_full;
  logic [STAT_W-1:0] push_byte;

  assign rep       = '{intr_req: pkt_intr_req, jabber: pkt_jabber,
                       underrun: pkt_underrun, max_coll: pkt_max_coll};
  assign push_req  = pkt_done & txc_worth_queuing(rep);
  assign fatal_req = pkt_done & txc_is_fatal(rep);
  assign push_byte = txc_encode(rep);

  txc_ring #(
    .DEPTH  (DEPTH),
    .WIDTH  (STAT_W),
    .OVF_BIT(BIT_OVERFLOW)
  ) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (tx_reset),
    .wr_en  (push_req),
    .wr_data(push_byte),
    .rd_en  (host_pop),
    .head   (host_status),
    .empty  (ring_empty),
    .full   (ring_full)
  );

  txc_fatal_latch u_fatal (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_reset    (tx_reset),
    .fatal_report(fatal_req),
    .overrun_evt (fifo_overrun),
    .tx_disabled (tx_disabled),
    .overrun_flag(tx_overrun_flag),
    .fail_pulse  (adapter_fail)
  );

  assign tx_complete = ~ring_empty;

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_complete |-> (host_status == 8'h00)); // R4
  AST_HEAD_COMPLETE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_complete |-> (host_status[BIT_COMPLETE] && host_status[1:0] == 2'b00)); // R1
  AST_CLEAN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !push_req && !host_pop && !tx_reset) |=> $stable(host_status)); // R2
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> tx_complete); // R7

endmodule

// File: tb/tb_txc_status_queue.sv
module tb_txc_status_queue;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 26;

  typedef struct packed {
    logic       done, intr, jab, und, mcol, ovr, pop, trst;
    logic [7:0] rd;
    logic       cmp, dis, fail;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(input logic [7:0] stim, input logic [7:0] rd,
                              input logic cmp, input logic dis, input logic fail,
                              input logic [3:0] req);
    vec_t v;
    {v.done, v.intr, v.jab, v.und, v.mcol, v.ovr, v.pop, v.trst} = stim;
    v.rd = rd; v.cmp = cmp; v.dis = dis; v.fail = fail; v.req = req;
    return v;
  endfunction

  // stim bits: done intr jab und mcol ovr pop trst
  localparam vec_t VEC [NVEC] = '{
    mk(8'b1000_0000, 8'h00, 0, 0, 0, 2),  // R2 clean packet ignored
    mk(8'b1100_0000, 8'hC0, 1, 0, 0, 1),  // R1 intr report
    mk(8'b1000_1000, 8'hC0, 1, 0, 0, 8),  // R8 max-coll does not disable
    mk(8'b0000_0010, 8'h88, 1, 0, 0, 3),  // R3 pop reveals next
    mk(8'b0000_0010, 8'h00, 0, 0, 0, 7),  // R7 empty drops event
    mk(8'b0000_0010, 8'h00, 0, 0, 0, 4),  // R4 pop on empty
    mk(8'b1100_1000, 8'hC8, 1, 0, 0, 1),  // R1
    mk(8'b1000_1000, 8'hC8, 1, 0, 0, 3),  // R3
    mk(8'b1100_0000, 8'hC8, 1, 0, 0, 3),  // R3
    mk(8'b1000_1000, 8'hC8, 1, 0, 0, 5),  // R5 now full
    mk(8'b1100_0000, 8'hC8, 1, 0, 0, 5),  // R5 dropped, newest marked
    mk(8'b1100_0010, 8'h88, 1, 0, 0, 6),  // R6 push+pop when full
    mk(8'b0000_0010, 8'hC0, 1, 0, 0, 3),  // R3
    mk(8'b0000_0010, 8'h8C, 1, 0, 0, 5),  // R5 overflow bit seen
    mk(8'b0000_0010, 8'hC0, 1, 0, 0, 6),  // R6 report stored on full
    mk(8'b0000_0010, 8'h00, 0, 0, 0, 7),  // R7
    mk(8'b1010_0000, 8'hA0, 1, 1, 0, 8),  // R8 jabber disables
    mk(8'b0000_0000, 8'hA0, 1, 1, 0, 8),  // R8 holds
    mk(8'b0000_0001, 8'h00, 0, 0, 0, 10), // R10 reset empties and clears
    mk(8'b1001_0001, 8'h00, 0, 0, 0, 10), // R10 wins over push and fatal
    mk(8'b1001_0000, 8'h90, 1, 1, 0, 8),  // R8 underrun disables
    mk(8'b0000_0010, 8'h00, 0, 1, 0, 8),  // R8 pop leaves latch
    mk(8'b0000_0001, 8'h00, 0, 0, 0, 10), // R10
    mk(8'b0000_0100, 8'h00, 0, 1, 1, 9),  // R9 overrun
    mk(8'b0000_0000, 8'h00, 0, 1, 0, 9),  // R9 single pulse
    mk(8'b0000_0001, 8'h00, 0, 0, 0, 10)  // R10
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pkt_done, pkt_intr_req, pkt_jabber, pkt_underrun, pkt_max_coll;
  logic       fifo_overrun, host_pop, tx_reset;
  logic [7:0] host_status;
  logic       tx_complete, tx_disabled, tx_overrun_flag, adapter_fail;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  txc_status_queue #(.DEPTH(4)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .pkt_done       (pkt_done),
    .pkt_intr_req   (pkt_intr_req),
    .pkt_jabber     (pkt_jabber),
    .pkt_underrun   (pkt_underrun),
    .pkt_max_coll   (pkt_max_coll),
    .fifo_overrun   (fifo_overrun),
    .host_pop       (host_pop),
    .tx_reset       (tx_reset),
    .host_status    (host_status),
    .tx_complete    (tx_complete),
    .tx_disabled    (tx_disabled),
    .tx_overrun_flag(tx_overrun_flag),
    .adapter_fail   (adapter_fail)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] stim);
    {pkt_done, pkt_intr_req, pkt_jabber, pkt_underrun, pkt_max_coll,
     fifo_overrun, host_pop, tx_reset} = stim;
  endtask

  task automatic step(input logic [7:0] stim);
    drive(stim);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0;
    drive(8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 reset host_status", host_status, 8'h00);
    chk("R11 reset tx_complete", {7'd0, tx_complete}, 8'h00);
    chk("R11 reset tx_disabled", {7'd0, tx_disabled}, 8'h00);
    chk("R11 reset overrun flag", {7'd0, tx_overrun_flag}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      step({VEC[i].done, VEC[i].intr, VEC[i].jab, VEC[i].und,
            VEC[i].mcol, VEC[i].ovr, VEC[i].pop, VEC[i].trst});
      chk($sformatf("vec %0d R%0d host_status", i, VEC[i].req), host_status, VEC[i].rd);
      chk($sformatf("vec %0d R%0d tx_complete", i, VEC[i].req), {7'd0, tx_complete}, {7'd0, VEC[i].cmp});
      chk($sformatf("vec %0d R%0d tx_disabled", i, VEC[i].req), {7'd0, tx_disabled}, {7'd0, VEC[i].dis});
      chk($sformatf("vec %0d R%0d adapter_fail", i, VEC[i].req), {7'd0, adapter_fail}, {7'd0, VEC[i].fail});
    end

    // R9 overrun flag latches until tx reset
    step(8'b0000_0100);
    chk("R9 overrun flag set", {7'd0, tx_overrun_flag}, 8'h01);
    step(8'b0000_0000);
    chk("R9 overrun flag held", {7'd0, tx_overrun_flag}, 8'h01);
    step(8'b0000_0001);
    chk("R10 overrun flag cleared", {7'd0, tx_overrun_flag}, 8'h00);

    // R8 dropped fatal report still disables: fill with max-coll then jabber
    for (int k = 0; k < 4; k++) step(8'b1000_1000);
    step(8'b1010_0000);
    chk("R8 dropped jabber disables", {7'd0, tx_disabled}, 8'h01);
    chk("R5 head after drop", host_status, 8'h88);

    // R11 asynchronous reset mid-run
    drive(8'h00);
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    #(CLK_PERIOD / 4);
    chk("R11 async reset queue", {7'd0, tx_complete}, 8'h00);
    chk("R11 async reset disable", {7'd0, tx_disabled}, 8'h00);
    chk("R11 async reset status", host_status, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule